// File: doc/BRIEF.md
# Multichannel PWM Generator with Shared Coarse Compare

The block drives many pulse-width modulated outputs from one free-running master counter. Instead of giving every channel a full-width duty register and comparator, all duty values live in a small two-bank memory. The memory is read one channel per clock, addressed by the low bits of the master counter. One shared comparator checks the upper part of each duty value against the coarse window that comes next. When they match, that channel's small fine comparator is armed for that window and ends the pulse on the exact clock.

A host loads new duty values through a simple write port, one channel per strobe. Writes always land in the bank that is not driving the outputs. A swap request makes the loaded bank the live one, starting on a period boundary. With the default parameters there are 63 outputs with 16-bit resolution. At a 65.536 MHz clock this gives a 1 kHz repetition rate.

Top module: `pwm_mux_gen`

## Requirements
- R1: The master counter is CNT_W bits wide and counts up by one every clock, so a period lasts 2^CNT_W clocks. Once outputs are live, every channel with a nonzero duty rises on the clock that follows the counter value 0. All channels rise on that same clock.
- R2: A channel with duty d in 1 to 2^CNT_W-1 stays high for exactly d consecutive clocks in each period. It is high while the counter reads 1 through d and low from the clock after the counter reads d.
- R3: A channel whose duty is 0 stays low for the whole period.
- R4: Each duty value splits into a coarse field (its upper CNT_W-FINE_W bits) and a fine field (its lower FINE_W bits). Pulse widths stay exact when the fine field is all zeros or all ones, and when the duty lies in the first or the last coarse window of the period. The per-channel arming changes only on a coarse window boundary.
- R5: After reset, all outputs stay low until the first bank swap takes effect.
- R6: Host writes go to the bank that is not live. Bank 1 is the write bank after reset. Such writes change neither the current period nor any later period until a swap is made.
- R7: A swap requested in a clock where the counter reads below 2^CNT_W-2^FINE_W takes effect in the next period. A request made later in the period takes effect one period after that. No period mixes duty values from both banks.
- R8: Channel index 2^FINE_W-1 may be written, but it drives no output and does not disturb any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Duty write strobe, one channel per clock |
| wr_ch_i | input | FINE_W | Channel index of the write |
| wr_duty_i | input | CNT_W | Duty value of the write |
| swap_req_i | input | 1 | Request to make the loaded bank live |
| pwm_o | output | 2^FINE_W-1 | PWM outputs, one bit per channel |

## Verification
The bench compares every output bit on every clock of whole periods against the expected pulse window. It uses duties at the extremes: zero, one, the maximum, fine fields of all zeros and all ones, and values in the first and last coarse windows. A design that arms one window late or one window early would stretch or shorten those pulses by a whole window. A design that does not let clear win over set would show a one-clock glitch on zero-duty channels. The bench issues swap requests on the last clock that still counts for the next period and on the first clock that does not. A design that switched banks at the wrap, rather than one window ahead, would mix banks in the first window. A design with the switch point off by one would move the change a whole period. Writes made while a period is running must leave the pulse widths of that period and of the following period untouched.

// File: rtl/pwm_mux_pkg.sv
package pwm_mux_pkg;

  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DEF_FINE_W = 6;

  // Counter value at which the final coarse window of a period begins.
  function automatic int unsigned last_win_start(input int unsigned cnt_w,
                                                 input int unsigned fine_w);
    return (1 << cnt_w) - (1 << fine_w);
  endfunction

endpackage

// File: rtl/pwm_duty_ram.sv
module pwm_duty_ram #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 16,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  // One write port and one registered read port (one clock of latency).
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
    rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/pwm_coarse_arm.sv
module pwm_coarse_arm #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FINE_W = 6,
  localparam int unsigned CH_N  = (1 << FINE_W) - 1,
  localparam int unsigned CRS_W = CNT_W - FINE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [CNT_W-1:0]              rdata_i,
  output logic [CH_N-1:0]               armed_o,
  output logic [CH_N-1:0][FINE_W-1:0]   fine_o
);

  // Stage registers that travel alongside the memory read.
  logic [FINE_W-1:0] chan_q, chan_d;
  logic [CRS_W-1:0]  tgt_q, tgt_d;
  logic              vld_q;

  logic [CH_N-1:0]             pend_q, pend_d, pend_hit;
  logic [CH_N-1:0]             arm_q, arm_d;
  logic [CH_N-1:0][FINE_W-1:0] pfine_q, pfine_d, pfine_hit;
  logic [CH_N-1:0][FINE_W-1:0] afine_q, afine_d;
  logic                        hit;
  logic                        win_end;

  always_comb begin
    chan_d  = cnt_i[FINE_W-1:0];
    // The entry read now is compared against the coarse window that follows.
    tgt_d   = CRS_W'(cnt_i[CNT_W-1:FINE_W] + CRS_W'(1));
    win_end = (cnt_i[FINE_W-1:0] == '1);

    // One shared coarse comparator; the spare last slot absorbs read latency.
    hit = vld_q && (chan_q != '1) && (rdata_i[CNT_W-1:FINE_W] == tgt_q);

    pend_hit  = pend_q;
    pfine_hit = pfine_q;
    if (hit) begin
      pend_hit[chan_q]  = 1'b1;
      pfine_hit[chan_q] = rdata_i[FINE_W-1:0];
    end

    pend_d  = pend_hit;
    pfine_d = pfine_hit;
    arm_d   = arm_q;
    afine_d = afine_q;
    if (win_end) begin
      arm_d   = pend_hit;
      afine_d = pfine_hit;
      pend_d  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q  <= '0;
      tgt_q   <= '0;
      vld_q   <= 1'b0;
      pend_q  <= '0;
      arm_q   <= '0;
      pfine_q <= '0;
      afine_q <= '0;
    end else begin
      chan_q  <= chan_d;
      tgt_q   <= tgt_d;
      vld_q   <= 1'b1;
      pend_q  <= pend_d;
      arm_q   <= arm_d;
      pfine_q <= pfine_d;
      afine_q <= afine_d;
    end
  end

  assign armed_o = arm_q;
  assign fine_o  = afine_q;

endmodule

// File: rtl/pwm_fine_bank.sv
module pwm_fine_bank #(
  parameter int unsigned FINE_W = 6,
  localparam int unsigned CH_N  = (1 << FINE_W) - 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        live_i,
  input  logic                        wrap_i,
  input  logic [FINE_W-1:0]           fine_cnt_i,
  input  logic [CH_N-1:0]             armed_i,
  input  logic [CH_N-1:0][FINE_W-1:0] fine_i,
  output logic [CH_N-1:0]             pwm_o
);

  for (genvar k = 0; k < CH_N; k++) begin : g_ch
    logic fire;
    logic out_q, out_d;

    // Small per-channel comparator, active only inside its armed window.
    assign fire = armed_i[k] && (fine_i[k] == fine_cnt_i);

    always_comb begin
      out_d = out_q;
      if (live_i && wrap_i) begin
        out_d = 1'b1;
      end
      if (fire) begin
        out_d = 1'b0;  // clear wins, so a zero duty never shows a pulse
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q <= 1'b0;
      end else begin
        out_q <= out_d;
      end
    end

    assign pwm_o[k] = out_q;
  end

endmodule

// File: rtl/pwm_mux_gen.sv
module pwm_mux_gen #(
  parameter int unsigned CNT_W  = pwm_mux_pkg::DEF_CNT_W,
  parameter int unsigned FINE_W = pwm_mux_pkg::DEF_FINE_W,
  localparam int unsigned CH_N  = (1 << FINE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [FINE_W-1:0] wr_ch_i,
  input  logic [CNT_W-1:0]  wr_duty_i,
  input  logic              swap_req_i,
  output logic [CH_N-1:0]   pwm_o
);

  // The read bank flips on the edge that enters the last coarse window.
  localparam logic [CNT_W-1:0] SW_CNT =
    CNT_W'(pwm_mux_pkg::last_win_start(CNT_W, FINE_W) - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic rd_bank_q, rd_bank_d;
  logic swap_pend_q, swap_pend_d;
  logic started_q, started_d;
  logic live_q, live_d;
  logic wrap;

  logic [CNT_W-1:0]             rd_data;
  logic [CH_N-1:0]              armed;
  logic [CH_N-1:0][FINE_W-1:0]  fine_val;

  always_comb begin
    cnt_d       = cnt_q + CNT_W'(1);
    rd_bank_d   = rd_bank_q;
    started_d   = started_q;
    swap_pend_d = swap_pend_q | swap_req_i;
    if (cnt_q == SW_CNT) begin
      rd_bank_d   = rd_bank_q ^ (swap_pend_q | swap_req_i);
      started_d   = started_q | swap_pend_q | swap_req_i;
      swap_pend_d = 1'b0;
    end
    live_d = (cnt_q == '1) ? started_q : live_q;
    wrap   = (cnt_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      rd_bank_q   <= 1'b0;
      swap_pend_q <= 1'b0;
      started_q   <= 1'b0;
      live_q      <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      rd_bank_q   <= rd_bank_d;
      swap_pend_q <= swap_pend_d;
      started_q   <= started_d;
      live_q      <= live_d;
    end
  end

  pwm_duty_ram #(
    .AW(FINE_W + 1),
    .DW(CNT_W)
  ) u_ram (
    .clk_i  (clk_i),
    .we_i   (wr_en_i),
    .waddr_i({~rd_bank_q, wr_ch_i}),
    .wdata_i(wr_duty_i),
    .raddr_i({rd_bank_q, cnt_q[FINE_W-1:0]}),
    .rdata_o(rd_data)
  );

  pwm_coarse_arm #(
    .CNT_W (CNT_W),
    .FINE_W(FINE_W)
  ) u_arm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt_q),
    .rdata_i(rd_data),
    .armed_o(armed),
    .fine_o (fine_val)
  );

  pwm_fine_bank #(
    .FINE_W(FINE_W)
  ) u_fine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .live_i    (live_q),
    .wrap_i    (wrap),
    .fine_cnt_i(cnt_q[FINE_W-1:0]),
    .armed_i   (armed),
    .fine_i    (fine_val),
    .pwm_o     (pwm_o)
  );

endmodule

// File: rtl/pwm_mux_gen_chk.sv
module pwm_mux_gen_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FINE_W = 6,
  localparam int unsigned CH_N  = (1 << FINE_W) - 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic             rd_bank_i,
  input logic             live_i,
  input logic [CH_N-1:0]  armed_i,
  input logic [CH_N-1:0]  pwm_i
);

  localparam logic [CNT_W-1:0] LAST_START =
    CNT_W'(pwm_mux_pkg::last_win_start(CNT_W, FINE_W));

  // R1: the master counter advances by exactly one per clock
  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (cnt_i == CNT_W'($past(cnt_i) + CNT_W'(1))));

  // R1: rising edges only appear right after the counter has read zero
  a_r1_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pwm_i & ~$past(pwm_i))) |-> (cnt_i == CNT_W'(1)));

  // R5: nothing is driven high before the outputs are live
  a_r5_quiet_until_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_i |=> (pwm_i == '0));

  // R7: the read bank flips only when the last coarse window begins
  a_r7_bank_flip_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_bank_i != $past(rd_bank_i)) |-> (cnt_i == LAST_START));

  // R4: arming changes only on a coarse window boundary
  a_r4_arm_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i != $past(armed_i)) |-> (cnt_i[FINE_W-1:0] == '0));

endmodule

bind pwm_mux_gen pwm_mux_gen_chk #(
  .CNT_W (CNT_W),
  .FINE_W(FINE_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_i    (cnt_q),
  .rd_bank_i(rd_bank_q),
  .live_i   (live_q),
  .armed_i  (armed),
  .pwm_i    (pwm_o)
);

// File: tb/pwm_mux_gen_tb_top.sv
module pwm_mux_gen_tb_top;

  localparam int CW  = 10;
  localparam int FW  = 3;
  localparam int P   = 1 << CW;
  localparam int NCH = (1 << FW) - 1;
  localparam int NSL = 1 << FW;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en;
  logic [FW-1:0]  wr_ch;
  logic [CW-1:0]  wr_duty;
  logic           swap_req;
  logic [NCH-1:0] pwm;

  int cyc;
  int n_chk;
  int n_fail;
  bit done;

  // Slot 7 carries the never-used channel index (R8).
  int zero_d [NSL] = '{0, 0, 0, 0, 0, 0, 0, 0};
  int set_a  [NSL] = '{0, 1, 7, 8, 1023, 515, 1016, 5};
  int set_b  [NSL] = '{1022, 0, 9, 1015, 2, 64, 511, 1000};

  always #10 clk = ~clk;

  pwm_mux_gen #(
    .CNT_W (CW),
    .FINE_W(FW)
  ) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_ch_i   (wr_ch),
    .wr_duty_i (wr_duty),
    .swap_req_i(swap_req),
    .pwm_o     (pwm)
  );

  // Clock edges since reset release: the counter value is cyc mod P.
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic go_to(input int ph);
    while ((cyc % P) != ph) @(negedge clk);
  endtask

  task automatic put_duties(input int d [NSL]);
    for (int ch = 0; ch < NSL; ch++) begin
      wr_en   = 1'b1;
      wr_ch   = FW'(ch);
      wr_duty = CW'(d[ch]);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic pulse_swap();
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
  endtask

  // Compares every output on every clock of one full period.
  task automatic check_period(input int d [NSL], input bit on, input string tag);
    int errs [NCH];
    for (int k = 0; k < NCH; k++) errs[k] = 0;
    go_to(0);
    for (int p = 0; p < P; p++) begin
      for (int k = 0; k < NCH; k++) begin
        if (pwm[k] !== (on && p >= 1 && p <= d[k])) errs[k]++;
      end
      @(negedge clk);
    end
    for (int k = 0; k < NCH; k++) begin
      chk(errs[k] == 0, tag,
          $sformatf("ch%0d duty %0d mismatching clocks", k, d[k]), errs[k], 0);
    end
  endtask

  // R5: quiet after reset while bank 1 is loaded and a swap is requested
  task automatic t_reset_and_load();
    chk(pwm == '0, "R5", "outputs right after reset", int'(pwm), 0);
    fork
      check_period(zero_d, 1'b0, "R5");
      begin
        go_to(20);
        put_duties(set_a);
        go_to(500);
        pulse_swap();
      end
    join
  endtask

  // R1 R2 R3 R4 R8: first live period shows set A exactly
  task automatic t_first_live();
    check_period(set_a, 1'b1, "R1 R2 R3 R4 R8");
  endtask

  // R6: writes to the idle bank leave this and the next period unchanged
  task automatic t_inactive_writes();
    fork
      check_period(set_a, 1'b1, "R6");
      begin
        go_to(20);
        put_duties(set_b);
      end
    join
    check_period(set_a, 1'b1, "R6");
  endtask

  // R7: request on the last clock that still counts for the next period
  task automatic t_swap_early();
    fork
      check_period(set_a, 1'b1, "R7");
      begin
        go_to(P - NSL - 1);
        pulse_swap();
      end
    join
    check_period(set_b, 1'b1, "R7 R2 R3 R4");
  endtask

  // R7: request inside the final window waits one more period
  task automatic t_swap_late();
    fork
      check_period(set_b, 1'b1, "R7");
      begin
        go_to(P - NSL);
        pulse_swap();
      end
    join
    check_period(set_b, 1'b1, "R7");
    check_period(set_a, 1'b1, "R7");
  endtask

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    wr_ch    = '0;
    wr_duty  = '0;
    swap_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_load();
    t_first_live();
    t_inactive_writes();
    t_swap_early();
    t_swap_late();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule